// File: doc/BRIEF.md
# Late-Write Synchronous Burst SRAM

This block is a synchronous single-port SRAM model whose write data follows its command by the same number of clocks as read data does. Reads and writes can therefore alternate on every edge without idle cycles on the shared data bus. A static mode input picks one of two read paths. With the registered output path, read data reaches the bus one edge after the access and write data follows the command by two edges. With the direct path, read data appears right after the command edge and write data follows by one edge.

Accesses start with an external address or continue a burst from an internal two-bit counter. The counter visits four words in either sequential or XOR order. An active-low clock enable freezes the whole pipeline. A separate output enable can only switch the bus off. A sleep request idles the block without losing the array contents. The bidirectional bus appears as separate input data, output data and output-enable signals. When a registered-mode read comes right after a write to the same word, it returns the bytes of that write even though they reach the array on the same edge.

Top module: `lw_burst_sram`

## Requirements
- R1: With `flow_sel`=0, a read accepted at edge k drives `data_oe`=1 and the stored word on `data_out` from edge k+1 until the next accepted edge.
- R2: With `flow_sel`=0, a write accepted at edge k stores `data_in` as sampled at the second accepted edge after it (k+2).
- R3: With `flow_sel`=1, a read accepted at edge k drives its word right after edge k, and a write accepted at edge k stores `data_in` sampled at edge k+1.
- R4: A load (`burst_next`=0) starts an access only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise the cycle is a deselect, and its data phase leaves `data_oe`=0.
- R5: With `burst_next`=1 the previous access type continues at the next burst address, and chip enables and `we_n` are ignored. A continue after a deselect remains a deselect.
- R6: Burst address bits [1:0] are (start + i) mod 4 when `burst_ilv`=0 and start XOR i when `burst_ilv`=1, for i = 0..3 and then wrapping. The upper address bits are kept.
- R7: `byte_wr_n[j]`=0 writes bits [9j+8:9j]. A write with all bits of `byte_wr_n` high changes nothing.
- R8: An edge with `clk_en_n`=1 is ignored. All pipeline state, the array and the bus hold their values.
- R9: `oe_n`=1 forces `data_oe`=0 without waiting for a clock. The bus is never driven in a write data phase.
- R10: Two edges after `sleep_req` rises, commands are treated as deselects and `data_oe`=0. Two edges after it falls, commands are accepted again, and the array keeps its contents throughout.
- R11: With `flow_sel`=0, a read issued on the edge after a write to the same address returns the written bytes merged with the old ones.
- R12: After reset the bus is not driven (`data_oe`=0, `data_out`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flow_sel | input | 1 | 1 = direct read path, 0 = registered read path (static) |
| burst_ilv | input | 1 | 1 = XOR burst order, 0 = sequential order |
| clk_en_n | input | 1 | Active-low clock enable; high ignores the edge |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | 0 = write, 1 = read, sampled on a load |
| byte_wr_n | input | LANES | Active-low byte enables, one per 9-bit lane |
| burst_next | input | 1 | 1 = continue burst, 0 = load external address |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep_req | input | 1 | Sleep request, active high |
| data_in | input | LANES*LANE_W | Write data from the bus |
| data_out | output | LANES*LANE_W | Read data to the bus, zero when not driven |
| data_oe | output | 1 | Bus drive enable |

## Verification
A behavioural reference in the bench tracks the array and the pending accesses, and it is compared with the outputs on every clock. The first pattern fills the array and then reads it back. This separates the write latency from the read latency, since data sampled at the wrong edge shows up as the wrong word. The bench then interleaves writes and reads to the same address with partial byte enables. This exposes missing forwarding and errors in byte lanes. Bursts in both orders, continues after deselects, stalls, output-enable toggles, sleep entry and exit, and random mixes in both modes each isolate one rule: the address sequence, frozen state, asynchronous bus release, or commands that must be ignored.

// File: rtl/lw_burst_sram_pkg.sv
package lw_burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } access_e;

  // Low address bits of the i-th beat of a four-beat burst.
  function automatic logic [1:0] beat_lsb(input logic [1:0] origin,
                                          input logic [1:0] beat,
                                          input logic       xor_order);
    beat_lsb = xor_order ? (origin ^ beat) : (origin + beat);
  endfunction

endpackage

// File: rtl/lw_sleep_ctl.sv
module lw_sleep_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic asleep
);

  logic [1:0] req_q;
  logic [1:0] req_d;

  always_comb begin
    req_d = {req_q[0], sleep_req};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 2'b00;
    else        req_q <= req_d;
  end

  assign asleep = req_q[1];

endmodule

// File: rtl/lw_burst_issue.sv
module lw_burst_issue
  import lw_burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              asleep,
  input  logic              burst_ilv,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic              burst_next,
  input  logic [LANES-1:0]  byte_wr_n,
  input  logic [ADDR_W-1:0] addr,
  output access_e           op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  be_q
);

  access_e           op_d;
  logic [ADDR_W-1:0] addr_d;
  logic [LANES-1:0]  be_d;
  logic [1:0]        origin_q, origin_d;
  logic [1:0]        beat_q, beat_d;
  logic              chip_sel;

  assign chip_sel = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    op_d     = op_q;
    addr_d   = addr_q;
    origin_d = origin_q;
    beat_d   = beat_q;
    if (asleep) begin
      op_d = OP_IDLE;
    end else if (!burst_next) begin
      if (chip_sel) begin
        op_d     = we_n ? OP_RD : OP_WR;
        addr_d   = addr;
        origin_d = addr[1:0];
        beat_d   = 2'd0;
      end else begin
        op_d = OP_IDLE;
      end
    end else if (op_q != OP_IDLE) begin
      beat_d = beat_q + 2'd1;
      addr_d = {addr_q[ADDR_W-1:2], beat_lsb(origin_q, beat_d, burst_ilv)};
    end else begin
      op_d = OP_IDLE;
    end
    be_d = (op_d == OP_WR) ? ~byte_wr_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_IDLE;
      addr_q   <= '0;
      be_q     <= '0;
      origin_q <= '0;
      beat_q   <= '0;
    end else if (!clk_en_n) begin
      op_q     <= op_d;
      addr_q   <= addr_d;
      be_q     <= be_d;
      origin_q <= origin_d;
      beat_q   <= beat_d;
    end
  end

  // R4: a selected load captures the external address
  assert_load_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !burst_next && chip_sel && !asleep) |=> (addr_q == $past(addr)));

  // R6: a continued burst moves the low bits and keeps the upper bits
  assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_next && !asleep && op_q != OP_IDLE) |=>
      ((addr_q[1:0] != $past(addr_q[1:0])) && (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]))));

  // R5: a continue after a deselect stays deselected
  assert_cont_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_next && op_q == OP_IDLE) |=> (op_q == OP_IDLE));

  // R8: a stalled edge keeps the issued access
  assert_issue_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(addr_q) && $stable(op_q)));

endmodule

// File: rtl/lw_lane_array.sv
module lw_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/lw_burst_sram.sv
module lw_burst_sram
  import lw_burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_sel,
  input  logic                    burst_ilv,
  input  logic                    clk_en_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        byte_wr_n,
  input  logic                    burst_next,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic                    sleep_req,
  input  logic [LANES*LANE_W-1:0] data_in,
  output logic [LANES*LANE_W-1:0] data_out,
  output logic                    data_oe
);

  localparam int DW = LANES * LANE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              asleep;
  access_e           op_a, op_b;
  logic [ADDR_W-1:0] addr_a, addr_b;
  logic [LANES-1:0]  be_a, be_b;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  wr_be;
  logic [DW-1:0]     rd_data;
  logic [DW-1:0]     rd_merged;
  logic              fwd_hit;
  logic [DW-1:0]     dout_q, dout_d;
  logic              drive_rd;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  lw_sleep_ctl u_sleep (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .sleep_req (sleep_req),
    .asleep    (asleep)
  );

  lw_burst_issue #(.ADDR_W(ADDR_W), .LANES(LANES)) u_issue (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .clk_en_n   (clk_en_n),
    .asleep     (asleep),
    .burst_ilv  (burst_ilv),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .we_n       (we_n),
    .burst_next (burst_next),
    .byte_wr_n  (byte_wr_n),
    .addr       (addr),
    .op_q       (op_a),
    .addr_q     (addr_a),
    .be_q       (be_a)
  );

  // second stage: data phase of the registered path
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_b   <= OP_IDLE;
      addr_b <= '0;
      be_b   <= '0;
    end else if (!clk_en_n) begin
      op_b   <= op_a;
      addr_b <= addr_a;
      be_b   <= be_a;
    end
  end

  // late write: one stage deep on the direct path, two on the registered one
  always_comb begin
    if (flow_sel) begin
      wr_en   = !clk_en_n && (op_a == OP_WR);
      wr_addr = addr_a;
      wr_be   = be_a;
    end else begin
      wr_en   = !clk_en_n && (op_b == OP_WR);
      wr_addr = addr_b;
      wr_be   = be_b;
    end
  end

  lw_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_be   (wr_be),
    .wr_data (data_in),
    .rd_addr (addr_a),
    .rd_data (rd_data)
  );

  // bytes landing on the same edge the output register loads
  assign fwd_hit = !flow_sel && (op_b == OP_WR) && (addr_b == addr_a);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign rd_merged[g*LANE_W +: LANE_W] = (fwd_hit && be_b[g]) ?
      data_in[g*LANE_W +: LANE_W] : rd_data[g*LANE_W +: LANE_W];
  end

  always_comb begin
    dout_d = dout_q;
    if (op_a == OP_RD) dout_d = rd_merged;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)       dout_q <= '0;
    else if (!clk_en_n) dout_q <= dout_d;
  end

  assign drive_rd = flow_sel ? (op_a == OP_RD) : (op_b == OP_RD);
  assign data_oe  = drive_rd && !oe_n && !asleep;
  assign data_out = data_oe ? (flow_sel ? rd_data : dout_q) : '0;

  // R8: a stalled edge freezes the data stage and the output register
  assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    clk_en_n |=> ($stable(op_b) && $stable(addr_b) && $stable(dout_q)));

  // R4: a direct-path deselect leaves the bus undriven
  assert_desel_hiz_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!clk_en_n && !burst_next && ce1_n && flow_sel) |=> !data_oe);

endmodule

// File: tb/lw_burst_sram_bench.sv
`timescale 1ns/1ps
module lw_burst_sram_bench;
  localparam int AW = 6, NB = 4, BW = 9, DW = NB * BW, DEPTH = 1 << AW;
  localparam int C_DESEL = 0, C_DESEL2 = 1, C_DESEL3 = 2, C_RD = 3, C_WR = 4, C_CONT = 5, C_STALL = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, flow_sel, burst_ilv, clk_en_n, ce1_n, ce2, ce3_n, we_n, burst_next, oe_n, sleep_req;
  logic [NB-1:0] byte_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] data_in, data_out;
  logic data_oe;

  lw_burst_sram #(.ADDR_W(AW), .LANES(NB), .LANE_W(BW)) u_lw_burst_sram (
    .clk(clk), .rst_n(rst_n), .flow_sel(flow_sel), .burst_ilv(burst_ilv),
    .clk_en_n(clk_en_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n),
    .byte_wr_n(byte_wr_n), .burst_next(burst_next), .addr(addr), .oe_n(oe_n),
    .sleep_req(sleep_req), .data_in(data_in), .data_out(data_out), .data_oe(data_oe));

  int nchk = 0, nfail = 0;
  bit chk_on = 0, done = 0;
  string tag = "R12";
  logic mode_flow = 0, mode_ilv = 0, want_oe_n = 0, want_sleep = 0;

  // reference: 0 idle, 1 read, 2 write
  logic [DW-1:0] m_mem [DEPTH];
  int            m_opA, m_opB;
  logic [AW-1:0] m_addrA, m_addrB;
  logic [NB-1:0] m_beA, m_beB;
  logic [1:0]    m_base, m_cnt;
  logic [DW-1:0] m_out;
  logic          m_s0, m_s1;

  task automatic mem_put(input logic [AW-1:0] a, input logic [NB-1:0] be, input logic [DW-1:0] d);
    for (int b = 0; b < NB; b++)
      if (be[b]) m_mem[a][b*BW +: BW] = d[b*BW +: BW];
  endtask

  task automatic model_edge();
    logic sl;
    sl = m_s1;
    m_s1 = m_s0;
    m_s0 = sleep_req;
    if (clk_en_n) return;
    if (flow_sel) begin
      if (m_opA == 2) mem_put(m_addrA, m_beA, data_in);
    end else begin
      if (m_opB == 2) mem_put(m_addrB, m_beB, data_in);
    end
    if (!flow_sel && m_opA == 1) m_out = m_mem[m_addrA];
    m_opB = m_opA; m_addrB = m_addrA; m_beB = m_beA;
    if (sl) m_opA = 0;
    else if (!burst_next) begin
      if (!ce1_n && ce2 && !ce3_n) begin
        m_opA = we_n ? 1 : 2; m_addrA = addr; m_base = addr[1:0]; m_cnt = 2'd0;
      end else m_opA = 0;
    end else if (m_opA != 0) begin
      m_cnt = m_cnt + 2'd1;
      m_addrA[1:0] = burst_ilv ? (m_base ^ m_cnt) : (m_base + m_cnt);
    end
    m_beA = (m_opA == 2) ? ~byte_wr_n : '0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_opA = 0; m_opB = 0; m_s0 = 0; m_s1 = 0; m_beA = '0; m_beB = '0;
    end else model_edge();
  end

  task automatic compare();
    logic          e_oe;
    logic [DW-1:0] e_d;
    if (!chk_on) return;
    e_oe = !oe_n && !m_s1 && (flow_sel ? (m_opA == 1) : (m_opB == 1));
    e_d  = flow_sel ? m_mem[m_addrA] : m_out;
    nchk++;
    if (data_oe !== e_oe || (e_oe && data_out !== e_d)) begin
      nfail++;
      $display("FAIL %s oe=%0b data=%h expected oe=%0b data=%h", tag, data_oe, data_out, e_oe, e_d);
    end
  endtask

  task automatic cyc(input int op, input logic [AW-1:0] a = '0, input logic [NB-1:0] bwn = '0);
    logic [63:0] r64;
    @(negedge clk);
    compare();
    r64 = {$urandom, $urandom};
    data_in = r64[DW-1:0];
    flow_sel = mode_flow; burst_ilv = mode_ilv; oe_n = want_oe_n; sleep_req = want_sleep;
    clk_en_n = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; burst_next = 0; we_n = 1; byte_wr_n = '1; addr = a;
    case (op)
      C_DESEL:  ce1_n = 1;
      C_DESEL2: ce2 = 0;
      C_DESEL3: ce3_n = 1;
      C_WR:     begin we_n = 0; byte_wr_n = bwn; end
      C_CONT:   begin burst_next = 1; byte_wr_n = bwn; ce1_n = 1; we_n = $urandom_range(1); end
      C_STALL:  begin clk_en_n = 1; burst_next = $urandom_range(1); we_n = $urandom_range(1); end
      default:  ;
    endcase
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) cyc(C_DESEL);
  endtask

  task automatic rand_mix(input int n, input int stall_pct);
    for (int i = 0; i < n; i++) begin
      int r;
      logic [AW-1:0] a;
      logic [NB-1:0] bw;
      r = $urandom_range(99);
      a = AW'($urandom_range(DEPTH - 1));
      bw = ($urandom_range(3) == 0) ? NB'($urandom) : '0;
      want_oe_n = ($urandom_range(7) == 0);
      if (r < stall_pct) cyc(C_STALL);
      else if (r < stall_pct + 25) cyc(C_RD, a);
      else if (r < stall_pct + 50) cyc(C_WR, a, bw);
      else if (r < stall_pct + 75) cyc(C_CONT, a, bw);
      else cyc(C_DESEL);
    end
    want_oe_n = 0;
  endtask

  initial begin
    rst_n = 0; flow_sel = 0; burst_ilv = 0; clk_en_n = 0; ce1_n = 1; ce2 = 1; ce3_n = 0;
    we_n = 1; byte_wr_n = '1; burst_next = 0; addr = '0; oe_n = 0; sleep_req = 0; data_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    flush(3);
    // R12: bus idle after reset
    @(negedge clk);
    nchk++;
    if (data_oe !== 1'b0 || data_out !== '0) begin
      nfail++;
      $display("FAIL R12 oe=%0b data=%h expected oe=0 data=0", data_oe, data_out);
    end
    chk_on = 1;

    tag = "R2";  for (int a = 0; a < DEPTH; a++) cyc(C_WR, AW'(a)); flush(3);
    tag = "R1";  for (int a = 0; a < DEPTH; a++) cyc(C_RD, AW'(a)); flush(3);
    tag = "R11";
    for (int a = 0; a < 16; a++) begin
      cyc(C_WR, AW'(a), NB'(a)); cyc(C_RD, AW'(a));
    end
    flush(3);
    tag = "R7";
    for (int a = 20; a < 28; a++) cyc(C_WR, AW'(a), ~(NB'(1) << (a % NB)));
    cyc(C_WR, 6'd30, '1); cyc(C_WR, 6'd31, '1);
    for (int a = 20; a < 32; a++) cyc(C_RD, AW'(a));
    flush(3);
    tag = "R4";
    for (int a = 0; a < 8; a++) begin
      cyc(C_RD, AW'(a)); cyc(C_DESEL2, AW'(a)); cyc(C_RD, AW'(a + 1)); cyc(C_DESEL3, AW'(a)); cyc(C_DESEL, AW'(a));
    end
    flush(3);
    tag = "R6";
    cyc(C_RD, 6'd5); for (int i = 0; i < 5; i++) cyc(C_CONT);
    cyc(C_WR, 6'd42); for (int i = 0; i < 3; i++) cyc(C_CONT);
    cyc(C_RD, 6'd40); for (int i = 0; i < 3; i++) cyc(C_CONT);
    flush(2); mode_ilv = 1; flush(2);
    cyc(C_RD, 6'd6); for (int i = 0; i < 5; i++) cyc(C_CONT);
    cyc(C_WR, 6'd49, 4'b0101); for (int i = 0; i < 3; i++) cyc(C_CONT, '0, 4'b1010);
    cyc(C_RD, 6'd48); for (int i = 0; i < 3; i++) cyc(C_CONT);
    flush(3); mode_ilv = 0;
    tag = "R5";
    cyc(C_DESEL); cyc(C_CONT); cyc(C_CONT); cyc(C_RD, 6'd9); cyc(C_CONT); cyc(C_DESEL2); cyc(C_CONT);
    flush(3);
    tag = "R9";
    for (int a = 0; a < 12; a++) begin
      want_oe_n = a[0]; cyc(C_RD, AW'(a)); cyc(C_WR, AW'(a + 1)); want_oe_n = 0; cyc(C_RD, AW'(a + 1));
    end
    flush(3);
    tag = "R8";  rand_mix(600, 25); flush(4);
    tag = "R10";
    want_sleep = 1; flush(2);
    for (int i = 0; i < 4; i++) begin cyc(C_WR, 6'd10); cyc(C_RD, 6'd10); end
    want_sleep = 0; flush(2);
    cyc(C_RD, 6'd10); cyc(C_RD, 6'd11); flush(3);
    tag = "R3";
    mode_flow = 1; flush(3);
    for (int a = 0; a < 16; a++) begin
      cyc(C_WR, AW'(a + 8), NB'(a)); cyc(C_RD, AW'(a + 8)); cyc(C_RD, AW'(a));
    end
    cyc(C_RD, 6'd17); cyc(C_STALL); cyc(C_CONT); cyc(C_STALL); cyc(C_CONT);
    rand_mix(800, 20); flush(3);
    mode_ilv = 1; rand_mix(400, 20); flush(3);
    tag = "R8";  mode_flow = 0; flush(3); rand_mix(800, 20); flush(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL %s watchdog actual=timeout expected=finished", tag);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule